// File: doc/BRIEF.md
# Timer Channel Flag and Request Router

This block holds the event flag of a single timer channel and turns it into a service request. A one-cycle event pulse from the channel logic sets the flag. Two configuration bits then decide where the flag goes: a DMA-mode bit and a channel interrupt-enable bit. The flag can drive an interrupt line, drive a DMA request line, or stay internal for software to poll.

The flag can be cleared in two ways. The first is a transfer-done strobe from the DMA engine. The second is a software handshake on the register bus: the status register is read while the flag is set, and then a zero is written to the flag bit. Which of these two paths is allowed depends on the configuration. When DMA mode and interrupt enable are both on, only the DMA engine can retire the flag. This stops software from discarding a request that the DMA engine still owns.

All three outputs are registered. They change on the clock edge after the inputs that caused the change. Configuration changes show up on the request lines one edge later.

Top module: `chflag_ctrl`

## Requirements
- R1: An event pulse sampled at a clock edge makes flag_o 1 after that edge.
- R2: When an event pulse and any clear condition occur at the same edge, the flag is 1 after the edge.
- R3: With dma_en_i=0, irq_o equals flag AND irq_en_i, and dma_req_o is 0. Both outputs are registered and use the configuration sampled at the edge.
- R4: With dma_en_i=1 and irq_en_i=1, dma_req_o follows the flag and irq_o is 0.
- R5: With dma_en_i=1 and irq_en_i=0, both irq_o and dma_req_o are 0.
- R6: With dma_en_i=1 and irq_en_i=1, only dma_done_i clears the flag. A zero write is ignored, even when a status read taken while the flag was set came before it.
- R7: With dma_en_i=1 and irq_en_i=0, the flag is cleared by dma_done_i or by the software handshake.
- R8: With dma_en_i=0, dma_done_i has no effect, and the software handshake clears the flag.
- R9: The software handshake is a read strobe while the flag is 1, then a write strobe with data bit 0 at a later edge. A zero write with no prior armed read does not clear the flag. A read taken while the flag is 0 does not arm the handshake.
- R10: The armed state is dropped when the flag clears by any path, and it is also dropped by any write. A later zero write then needs a new read.
- R11: A write strobe with data bit 1 has no effect on the flag.
- R12: While rst is 1, and after it is released, all outputs and internal state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Channel event pulse |
| dma_en_i | input | 1 | DMA mode select |
| irq_en_i | input | 1 | Channel interrupt enable |
| dma_done_i | input | 1 | DMA transfer-done strobe |
| rd_stb_i | input | 1 | Status register read strobe |
| wr_stb_i | input | 1 | Status register write strobe |
| wr_flag_i | input | 1 | Flag bit value carried by the write |
| flag_o | output | 1 | Channel flag |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA transfer request |

## Verification
The bench targets the following corner cases, each of which catches a specific bug:
- **Handshake in the locked mode (R6).** A read-then-zero-write in the mode where the interrupt is enabled with DMA on. A design that lets software clear here drops a pending DMA request.
- **Stale arming (R9, R10).** A zero write with no read before it, a read taken while the flag was low, and a read followed by a DMA-done clear, a new event and then a zero write. A design that keeps arming too long clears a fresh flag that software never saw.
- **Set-versus-clear collisions (R2).** Events that coincide with a done strobe or with an armed zero write. A design that lets the clear win loses an event.
- **Routing (R3, R4, R5, R8).** Each mode is checked against both request lines. In DMA-off mode the bench pulses done, which a design must ignore there.

// File: rtl/chflag_pkg.sv
package chflag_pkg;

  // Where a set flag is routed
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_IRQ  = 2'd1,
    ROUTE_DMA  = 2'd2
  } route_e;

  // Clear and route policy derived from the configuration bits
  typedef struct packed {
    logic   hw_clr_ok;
    logic   sw_clr_ok;
    route_e route;
  } policy_t;

endpackage

// File: rtl/chflag_mode_dec.sv
module chflag_mode_dec
  import chflag_pkg::*;
(
  input  logic    dma_en,
  input  logic    irq_en,
  output policy_t pol
);

  always_comb begin
    pol.hw_clr_ok = dma_en;
    pol.sw_clr_ok = !(dma_en && irq_en);
    if (!irq_en)     pol.route = ROUTE_NONE;
    else if (dma_en) pol.route = ROUTE_DMA;
    else             pol.route = ROUTE_IRQ;
  end

endmodule

// File: rtl/chflag_core.sv
module chflag_core (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic hw_clr,
  input  logic sw_clr,
  output logic flag_q,
  output logic flag_nxt
);

  always_comb begin
    if (set_evt)               flag_nxt = 1'b1;
    else if (hw_clr || sw_clr) flag_nxt = 1'b0;
    else                       flag_nxt = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt;
  end

endmodule

// File: rtl/chflag_arm.sv
module chflag_arm (
  input  logic clk,
  input  logic rst,
  input  logic flag_q,
  input  logic flag_nxt,
  input  logic rd_stb,
  input  logic wr_stb,
  output logic arm_q
);

  logic arm_nxt;

  // Arm on a read seen while set; a write consumes it; a cleared flag drops it
  always_comb begin
    arm_nxt = arm_q;
    if (wr_stb)           arm_nxt = 1'b0;
    if (rd_stb && flag_q) arm_nxt = 1'b1;
    if (!flag_nxt)        arm_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= arm_nxt;
  end

endmodule

// File: rtl/chflag_ctrl.sv
module chflag_ctrl
  import chflag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic dma_en_i,
  input  logic irq_en_i,
  input  logic dma_done_i,
  input  logic rd_stb_i,
  input  logic wr_stb_i,
  input  logic wr_flag_i,
  output logic flag_o,
  output logic irq_o,
  output logic dma_req_o
);

  policy_t pol;
  logic    flag_q, flag_nxt, arm_q;
  logic    hw_clr, sw_clr;

  chflag_mode_dec u_dec (
    .dma_en (dma_en_i),
    .irq_en (irq_en_i),
    .pol    (pol)
  );

  assign hw_clr = dma_done_i && pol.hw_clr_ok;
  assign sw_clr = wr_stb_i && !wr_flag_i && arm_q && pol.sw_clr_ok;

  chflag_core u_core (
    .clk      (clk),
    .rst      (rst),
    .set_evt  (evt_i),
    .hw_clr   (hw_clr),
    .sw_clr   (sw_clr),
    .flag_q   (flag_q),
    .flag_nxt (flag_nxt)
  );

  chflag_arm u_arm (
    .clk      (clk),
    .rst      (rst),
    .flag_q   (flag_q),
    .flag_nxt (flag_nxt),
    .rd_stb   (rd_stb_i),
    .wr_stb   (wr_stb_i),
    .arm_q    (arm_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o    <= 1'b0;
      irq_o     <= 1'b0;
      dma_req_o <= 1'b0;
    end else begin
      flag_o    <= flag_nxt;
      irq_o     <= flag_nxt && (pol.route == ROUTE_IRQ);
      dma_req_o <= flag_nxt && (pol.route == ROUTE_DMA);
    end
  end

endmodule

// File: rtl/chflag_ctrl_chk.sv
module chflag_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic evt_i,
  input logic dma_en_i,
  input logic irq_en_i,
  input logic dma_done_i,
  input logic wr_stb_i,
  input logic wr_flag_i,
  input logic arm_q,
  input logic flag_o,
  input logic irq_o,
  input logic dma_req_o
);

  p_set_r1: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> flag_o);

  p_no_dma_req_r3: assert property (@(posedge clk) disable iff (rst)
    !dma_en_i |=> !dma_req_o);

  p_no_irq_r4: assert property (@(posedge clk) disable iff (rst)
    dma_en_i |=> !irq_o);

  p_locked_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_o && dma_en_i && irq_en_i && !dma_done_i) |=> flag_o);

  p_unarmed_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !arm_q && !(dma_en_i && dma_done_i)) |=> flag_o);

  p_write_one_r11: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !evt_i && wr_stb_i && wr_flag_i) |=> !flag_o);

endmodule

bind chflag_ctrl chflag_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_i      (evt_i),
  .dma_en_i   (dma_en_i),
  .irq_en_i   (irq_en_i),
  .dma_done_i (dma_done_i),
  .wr_stb_i   (wr_stb_i),
  .wr_flag_i  (wr_flag_i),
  .arm_q      (arm_q),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .dma_req_o  (dma_req_o)
);

// File: tb/chflag_ctrl_tb.sv
module chflag_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic evt = 0, dma = 0, ie = 0, done = 0, rd = 0, wr = 0, wd = 0;
  logic flag_o, irq_o, dma_req_o;
  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  bit m_flag = 0, m_armed = 0, m_irq = 0, m_dma = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chflag_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .dma_en_i(dma), .irq_en_i(ie),
    .dma_done_i(done), .rd_stb_i(rd), .wr_stb_i(wr), .wr_flag_i(wd),
    .flag_o(flag_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "flag", flag_o, m_flag);
    check(tag, "irq", irq_o, m_irq);
    check(tag, "dma_req", dma_req_o, m_dma);
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input bit e, input bit d, input bit i, input bit dn,
                      input bit r, input bit w, input bit wv, input string tag);
    bit was_flag, clear_now;
    evt = e; dma = d; ie = i; done = dn; rd = r; wr = w; wd = wv;
    @(posedge clk);
    was_flag = m_flag;
    clear_now = 0;
    if (d && dn) clear_now = 1;
    if (w && !wv && m_armed && !(d && i)) clear_now = 1;
    if (e) m_flag = 1;
    else if (clear_now) m_flag = 0;
    if (w) m_armed = 0;
    if (r && was_flag) m_armed = 1;
    if (!m_flag) m_armed = 0;
    m_irq = m_flag && i && !d;
    m_dma = m_flag && i && d;
    @(negedge clk);
    compare(tag);
    evt = 0; done = 0; rd = 0; wr = 0; wd = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    @(negedge clk); evt = 1; dma = 1; ie = 1;
    @(negedge clk); compare("R12");
    @(negedge clk); rst = 0; evt = 0; dma = 0; ie = 0;
    compare("R12");

    // R1 / R3: DMA off routing
    step(0,0,1,0,0,0,0,"R12");
    step(1,0,1,0,0,0,0,"R1");
    step(0,0,0,0,0,0,0,"R3");
    step(0,0,1,0,0,0,0,"R3");
    // R8: done ignored with DMA off
    step(0,0,1,1,0,0,0,"R8");
    // R9: zero write without read
    step(0,0,1,0,0,1,0,"R9");
    // R11: write of one
    step(0,0,1,0,1,0,0,"R11");
    step(0,0,1,0,0,1,1,"R11");
    // R10: the write above consumed arming, so a zero write now must not clear
    step(0,0,1,0,0,1,0,"R10");
    // R8: handshake clears
    step(0,0,1,0,1,0,0,"R8");
    step(0,0,1,0,0,1,0,"R8");
    // R9: read while clear does not arm
    step(0,0,1,0,1,0,0,"R9");
    step(1,0,1,0,0,0,0,"R1");
    step(0,0,1,0,0,1,0,"R9");
    // R11: write one while clear doesn't set
    step(0,0,1,0,1,0,0,"R11");
    step(0,0,1,0,0,1,0,"R8");
    step(0,0,1,0,0,1,1,"R11");

    // R4 / R6: DMA+IE locked mode
    step(1,1,1,0,0,0,0,"R4");
    step(0,1,1,0,1,0,0,"R6");
    step(0,1,1,0,0,1,0,"R6");
    step(0,1,1,0,0,0,0,"R4");
    step(0,1,1,1,0,0,0,"R6");
    // R2: event and done at same edge
    step(1,1,1,0,0,0,0,"R4");
    step(1,1,1,1,0,0,0,"R2");
    step(0,1,1,1,0,0,0,"R6");

    // R5 / R7: DMA on, IE off
    step(1,1,0,0,0,0,0,"R5");
    step(0,1,0,1,0,0,0,"R7");
    step(1,1,0,0,0,0,0,"R5");
    step(0,1,0,0,1,0,0,"R7");
    step(0,1,0,0,0,1,0,"R7");
    // R10: arm dropped when done clears
    step(1,1,0,0,0,0,0,"R10");
    step(0,1,0,0,1,0,0,"R10");
    step(0,1,0,1,0,0,0,"R10");
    step(1,1,0,0,0,0,0,"R10");
    step(0,1,0,0,0,1,0,"R10");
    // R2: armed zero write with a new event
    step(0,1,0,0,1,0,0,"R2");
    step(1,1,0,0,0,1,0,"R2");
    step(0,1,0,0,0,1,0,"R10");
    // R3: mode switch back to interrupt routing
    step(0,0,1,0,0,0,0,"R3");
    step(0,1,1,0,0,0,0,"R4");
    step(0,1,0,0,0,0,0,"R5");

    // R12: reset in the middle clears everything
    @(negedge clk); rst = 1;
    @(posedge clk); m_flag = 0; m_armed = 0; m_irq = 0; m_dma = 0;
    @(negedge clk); rst = 0; compare("R12");
    step(0,0,1,0,0,1,0,"R12");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule